// File: doc/BRIEF.md
# Polled Asynchronous Serial Port

This block is a byte-wide asynchronous serial controller that a processor drives by polling a four-entry register bank over an 8-bit I/O bus. A write to the transmit register launches a character on the single transmit wire. A character that arrives on the single receive wire is assembled into the receive register, and a status register tells the processor that the transmitter can take another byte and that a received byte is waiting. A control register selects a 7- or 8-bit data field, turns parity on or off and chooses odd or even parity. The resulting frame is 9, 10 or 11 bit times long.

A frame is a low start bit, the data bits least significant first, the parity bit when it is enabled, and a high stop bit. Every bit lasts `CLKS_PER_BIT` clocks. The receive wire passes through a `SYNC_STAGES`-deep synchroniser and is sampled at the middle of each bit. The register interface has no back-pressure. A write to the transmit register while the transmitter is busy is dropped, and the processor is expected to poll the ready bit first. A new character overwrites the receive register whether or not the previous one was read.

Top module: `sio_port`

## Requirements
- R1: After reset `tx_o` is 1, the status register reads 0x01, and the control and receive registers read 0x00.
- R2: A write to address 0 accepted at a clock edge drives `tx_o` low from that edge for `CLKS_PER_BIT` clocks, followed by the data bits LSB first and then a stop bit of 1, each held for `CLKS_PER_BIT` clocks. Between frames the line stays at 1.
- R3: Control bit 0 selects the data length: 0 sends and receives 7 data bits (wdata[6:0]), 1 sends and receives 8.
- R4: Control bit 1 enables a parity bit between the data and the stop bit. Control bit 2 selects odd parity (1) or even parity (0), counted over the data bits and the parity bit together.
- R5: Status bit 0 (transmitter ready) clears at the edge that accepts a write and sets at the edge that ends the stop bit. A write to address 0 while the bit is 0 is ignored.
- R6: A received character sets status bit 1 (receiver full). Its data reads at address 1, with bit 7 reading 0 in 7-bit mode. The character is captured `SYNC_STAGES + CLKS_PER_BIT/2 + CLKS_PER_BIT*(frame bits-1)` clocks after the first clock edge that sees the start bit low.
- R7: A low level on `rx_i` that has gone high again by the middle of the start bit is discarded and sets no status bit.
- R8: A received parity bit that does not match the configured sense sets status bit 2 (parity error).
- R9: A stop bit received as 0 sets status bit 3 (framing error). The data is still stored.
- R10: A read of address 1 clears status bits 1, 2 and 3. Reads of the other addresses clear nothing.
- R11: When a character completes in the same cycle as a read of address 1, the read returns the previous byte. The new byte and its error flags are kept, and receiver full stays 1.
- R12: Address 3 is the control register, readable and writable in bits [2:0], with the upper bits reading 0. Writes to addresses 1 and 2 have no effect. Address 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, whose side effects apply at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |

## Verification
The one collision in this block is a character that completes in the same cycle in which the processor reads the receive register, with the set and the clear of receiver full landing on one edge. The bench fills the receive register, then sends a second character and places a one-cycle read of address 1 on the exact capture cycle that R6 gives. It judges the result by the byte returned during the read (the old one) and by a later status and data read that must show the new byte still pending. The transmitter is compared against a queue model on every clock, including a write that arrives on the final cycle of a stop bit.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int REG_AW = 2;
  localparam int BYTE_W = 8;
  localparam int FRAME_MAX = 11;

  localparam logic [REG_AW-1:0] A_TXD  = 2'd0;
  localparam logic [REG_AW-1:0] A_RXD  = 2'd1;
  localparam logic [REG_AW-1:0] A_STAT = 2'd2;
  localparam logic [REG_AW-1:0] A_CTRL = 2'd3;

  typedef struct packed {
    logic par_odd;
    logic par_en;
    logic len8;
  } sio_cfg_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_RECV} rx_state_t;
endpackage

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] data,
  input  sio_cfg_t          cfg,
  output logic              line,
  output logic              ready
);
  localparam int CW = $clog2(CLKS_PER_BIT);

  logic [FRAME_MAX-1:0] frame, sh;
  logic [3:0]           nbits, left;
  logic [CW-1:0]        cnt;
  logic                 busy;
  logic                 bit_end;

  always_comb begin
    logic p;
    p = ^(data & (cfg.len8 ? 8'hFF : 8'h7F)) ^ cfg.par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < BYTE_W; i++)
      if (i < BYTE_W-1 || cfg.len8) frame[1+i] = data[i];
    if (cfg.par_en) frame[cfg.len8 ? 9 : 8] = p;
    nbits = (cfg.len8 ? 4'd10 : 4'd9) + {3'b0, cfg.par_en};
  end

  assign bit_end = (cnt == CW'(CLKS_PER_BIT-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '1; left <= '0; cnt <= '0; busy <= 1'b0;
    end else if (!busy) begin
      if (load) begin
        sh <= frame; left <= nbits - 4'd1; cnt <= '0; busy <= 1'b1;
      end
    end else if (bit_end) begin
      cnt <= '0;
      if (left == 4'd0) busy <= 1'b0;
      else begin
        sh <= {1'b1, sh[FRAME_MAX-1:1]};
        left <= left - 4'd1;
      end
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign line  = sh[0];
  assign ready = !busy;

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ready) |=> !line); // R2
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> $stable(line)); // R2
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ready) |=> !ready); // R5
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_end && left == 4'd0) |=> (line && ready)); // R2
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  sio_cfg_t          cfg,
  output logic              done,
  output logic [BYTE_W-1:0] dout,
  output logic              perr,
  output logic              ferr
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;

  logic [SYNC_STAGES-1:0] sy;
  logic                   s;
  rx_state_t              st;
  logic [CW-1:0]          cnt;
  logic [3:0]             idx, last;
  logic [BYTE_W:0]        bits;
  logic                   pbit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '1;
    else        sy <= {sy[SYNC_STAGES-2:0], rx_i};
  assign s = sy[SYNC_STAGES-1];

  assign last = (cfg.len8 ? 4'd8 : 4'd7) + {3'b0, cfg.par_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; cnt <= '0; idx <= '0; bits <= '0;
    end else begin
      case (st)
        RX_IDLE: if (!s) begin st <= RX_START; cnt <= '0; end
        RX_START:
          if (cnt == CW'(HALF-1)) begin
            cnt <= '0; idx <= '0;
            st <= s ? RX_IDLE : RX_RECV;
          end else cnt <= cnt + CW'(1);
        RX_RECV:
          if (cnt == CW'(CLKS_PER_BIT-1)) begin
            cnt <= '0;
            if (idx == last) st <= RX_IDLE;
            else begin
              bits[idx] <= s;
              idx <= idx + 4'd1;
            end
          end else cnt <= cnt + CW'(1);
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign done = (st == RX_RECV) && (cnt == CW'(CLKS_PER_BIT-1)) && (idx == last);
  assign dout = cfg.len8 ? bits[7:0] : {1'b0, bits[6:0]};
  assign pbit = cfg.len8 ? bits[8] : bits[7];
  assign perr = cfg.par_en && (pbit ^ (^dout) ^ cfg.par_odd);
  assign ferr = !s;

  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_START && cnt == CW'(HALF-1) && s) |=> (st == RX_IDLE)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        tx_o,
  input  logic        rx_i
);
  sio_cfg_t          ctrl;
  logic              tx_ready, tx_load;
  logic              rx_done, rx_perr, rx_ferr;
  logic [BYTE_W-1:0] rx_data, rx_buf;
  logic              full_q, perr_q, ferr_q;
  logic              rd_rx;

  assign tx_load = wr_en && (addr == A_TXD);
  assign rd_rx   = rd_en && (addr == A_RXD);

  sio_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .data(wdata),
    .cfg(ctrl), .line(tx_o), .ready(tx_ready)
  );

  sio_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .cfg(ctrl),
    .done(rx_done), .dout(rx_data), .perr(rx_perr), .ferr(rx_ferr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (wr_en && addr == A_CTRL) ctrl <= sio_cfg_t'(wdata[2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf <= '0; full_q <= 1'b0; perr_q <= 1'b0; ferr_q <= 1'b0;
    end else if (rx_done) begin
      rx_buf <= rx_data; full_q <= 1'b1; perr_q <= rx_perr; ferr_q <= rx_ferr;
    end else if (rd_rx) begin
      full_q <= 1'b0; perr_q <= 1'b0; ferr_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_RXD:   rdata = rx_buf;
      A_STAT:  rdata = {4'b0, ferr_q, perr_q, full_q, tx_ready};
      A_CTRL:  rdata = {5'b0, ctrl};
      default: rdata = '0;
    endcase
  end

  AST_FULL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> full_q); // R11
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_done) |=> (!full_q && !perr_q && !ferr_q)); // R10
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_CTRL) |=> $stable(ctrl)); // R12
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(rx_buf)); // R6
endmodule

// File: tb/test_sio_port.sv
module test_sio_port;
  localparam int CPB = 16;
  localparam int SYN = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       tx_o;
  logic       rx_i = 1'b1;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 1'b0;
  logic q[$];
  logic [2:0] m_ctrl = 3'd0;

  always #5 clk = ~clk;

  sio_port #(.CLKS_PER_BIT(CPB), .SYNC_STAGES(SYN)) i_sio_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tx_o(tx_o), .rx_i(rx_i)
  );

  function automatic int frame_len(input logic [2:0] c);
    return (c[0] ? 10 : 9) + (c[1] ? 1 : 0);
  endfunction

  function automatic logic [10:0] frame_of(input logic [7:0] d, input logic [2:0] c);
    logic [10:0] f;
    int dl;
    int ones;
    dl = c[0] ? 8 : 7;
    f = '1;
    f[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < dl; i++) begin
      f[1+i] = d[i];
      if (d[i]) ones++;
    end
    if (c[1]) f[1+dl] = c[2] ? ((ones % 2) == 0) : ((ones % 2) == 1);
    return f;
  endfunction

  task automatic check8(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // transmit reference model: one queue entry per expected clock of line level
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_ctrl = 3'd0;
    end else begin
      if (q.size() != 0) void'(q.pop_front());
      else if (wr_en && addr == 2'd0) begin
        logic [10:0] fr;
        fr = frame_of(wdata, m_ctrl);
        for (int i = 0; i < frame_len(m_ctrl); i++)
          for (int k = 0; k < CPB; k++) q.push_back(fr[i]);
      end
      if (wr_en && addr == 2'd3) m_ctrl = wdata[2:0];
    end
  end

  always @(negedge clk) begin
    #2;
    if (!finished) begin
      logic e;
      string tag;
      e = (q.size() == 0) ? 1'b1 : q[0];
      tag = m_ctrl[1] ? "R4 tx_o" : (m_ctrl[0] ? "R3 tx_o" : "R2 tx_o");
      n_chk++;
      if (tx_o !== e) begin
        n_fail++;
        $display("FAIL %s got %b exp %b", tag, tx_o, e);
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_tx();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic [2:0] c,
                         input bit bad_par, input bit bad_stop);
    logic [10:0] f;
    int n;
    f = frame_of(d, c);
    n = frame_len(c);
    if (bad_par) f[c[0] ? 9 : 8] = ~f[c[0] ? 9 : 8];
    if (bad_stop) f[n-1] = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_i = f[i];
      repeat (CPB) @(negedge clk);
    end
    rx_i = 1'b1;
    repeat (2*CPB) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(2'd2, v); check8(v, 8'h01, "R1 status");
    bus_rd(2'd3, v); check8(v, 8'h00, "R1 ctrl");
    bus_rd(2'd1, v); check8(v, 8'h00, "R1 rxdata");

    // R2/R5 7-bit no parity; write while busy ignored
    bus_wr(2'd0, 8'hD5);
    bus_rd(2'd2, v); check8(v, 8'h00, "R5 ready clears");
    bus_wr(2'd0, 8'hFF);
    repeat (50) @(negedge clk);
    bus_wr(2'd0, 8'h0F);
    wait_tx();
    bus_rd(2'd2, v); check8(v, 8'h01, "R5 ready returns");

    // write landing on the final cycle of the stop bit is dropped (R5)
    bus_wr(2'd0, 8'h3A);
    while (q.size() != 1) @(negedge clk);
    bus_wr(2'd0, 8'h99);
    wait_tx();

    // R3 8-bit, R4 parity variants
    bus_wr(2'd3, 8'h01); bus_wr(2'd0, 8'hA7); wait_tx();
    bus_wr(2'd3, 8'h03); bus_wr(2'd0, 8'hA7); wait_tx();
    bus_wr(2'd3, 8'h07); bus_wr(2'd0, 8'h3C); wait_tx();
    bus_wr(2'd3, 8'h06); bus_wr(2'd0, 8'h7F); wait_tx();

    // R12 register map
    bus_wr(2'd3, 8'hFD);
    bus_rd(2'd3, v); check8(v, 8'h05, "R12 ctrl readback");
    bus_wr(2'd2, 8'hFF);
    bus_wr(2'd1, 8'hAA);
    bus_rd(2'd2, v); check8(v, 8'h01, "R12 status write ignored");
    bus_rd(2'd1, v); check8(v, 8'h00, "R12 rxdata write ignored");
    bus_rd(2'd0, v); check8(v, 8'h00, "R12 addr0 reads zero");

    // R6 receive 8-bit no parity
    bus_wr(2'd3, 8'h01);
    send_rx(8'hC3, 3'b001, 1'b0, 1'b0);
    bus_rd(2'd2, v); check8(v, 8'h03, "R6 full set");
    bus_rd(2'd2, v); check8(v, 8'h03, "R10 status read keeps full");
    bus_rd(2'd1, v); check8(v, 8'hC3, "R6 data 8-bit");
    bus_rd(2'd2, v); check8(v, 8'h01, "R10 full cleared");

    // R3/R6 7-bit receive: bit 7 reads 0
    bus_wr(2'd3, 8'h00);
    send_rx(8'hDA, 3'b000, 1'b0, 1'b0);
    bus_rd(2'd1, v); check8(v, 8'h5A, "R3 data 7-bit");

    // R4/R8 parity
    bus_wr(2'd3, 8'h03);
    send_rx(8'h96, 3'b011, 1'b0, 1'b0);
    bus_rd(2'd2, v); check8(v, 8'h03, "R4 even parity good");
    bus_rd(2'd1, v); check8(v, 8'h96, "R4 data");
    bus_wr(2'd3, 8'h06);
    send_rx(8'h41, 3'b110, 1'b0, 1'b0);
    bus_rd(2'd2, v); check8(v, 8'h03, "R4 odd parity 7-bit good");
    bus_rd(2'd1, v); check8(v, 8'h41, "R4 data odd");
    send_rx(8'h41, 3'b110, 1'b1, 1'b0);
    bus_rd(2'd2, v); check8(v, 8'h07, "R8 parity error");
    bus_rd(2'd1, v); check8(v, 8'h41, "R8 data");
    bus_rd(2'd2, v); check8(v, 8'h01, "R10 errors cleared");

    // R9 framing error
    bus_wr(2'd3, 8'h01);
    send_rx(8'h5E, 3'b001, 1'b0, 1'b1);
    bus_rd(2'd2, v); check8(v, 8'h0B, "R9 framing error");
    bus_rd(2'd1, v); check8(v, 8'h5E, "R9 data kept");
    bus_rd(2'd2, v); check8(v, 8'h01, "R10 framing cleared");

    // R7 glitch rejection
    rx_i = 1'b0;
    repeat (4) @(negedge clk);
    rx_i = 1'b1;
    repeat (200) @(negedge clk);
    bus_rd(2'd2, v); check8(v, 8'h01, "R7 glitch ignored");

    // R11 completion collides with read of receive register
    send_rx(8'h11, 3'b001, 1'b0, 1'b0);
    fork
      send_rx(8'h22, 3'b001, 1'b0, 1'b0);
      begin
        repeat (SYN + CPB/2 + CPB*9) @(negedge clk);
        bus_rd(2'd1, v);
        check8(v, 8'h11, "R11 read returns old byte");
      end
    join
    bus_rd(2'd2, v); check8(v, 8'h03, "R11 full stays set");
    bus_rd(2'd1, v); check8(v, 8'h22, "R11 new byte kept");

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule